// File: doc/BRIEF.md
# Serial-Access Secure Card Memory Controller

This block is the digital core of a contact card memory holding 192 one-bit cells, modelled as a register array. A host drives two lines, a card reset line and a card clock line. The block samples both on its own system clock and decodes their activity into four commands: read with pre-increment, address reset, bit program and byte erase. One registered data output carries the bit that the last read or reset selected. The address register is nine bits wide, so positions beyond the cell array can be reached. Those positions read as zero and accept no writes.

Writes are governed by access rights. The rights depend on the bit address and on a fuse input that selects between an issuer (initialisation) configuration and a user configuration. A program operation sets a single cell to 1. An erase clears the whole 8-bit row that holds the current address. In user configuration only the 48-bit counter window is writable. It behaves as six 8-bit stages that count by abacus rules: a lower stage may be cleared only once the stage above it holds a set bit. Every accepted write starts a busy window that stands in for the cell programming time. While the window is open the block ignores every command. A refused write leaves the cells alone and raises a sticky reject flag.

Top module: `scm_card_ctrl`

## Requirements
- R1: After the synchronous reset, io_out, busy and reject are 0, every cell is 0 except cells 0 to 15, and cell i in that range holds bit i of the CIRCUIT_ID parameter.
- R2: A rising edge of card_clk while card_rst is low is a READ. It adds 1 to the address (modulo 512) and then drives io_out with the cell at the new address.
- R3: A card_rst high interval that contains exactly one card_clk rising edge is a RESET when card_rst falls. The address becomes 0 and io_out shows cell 0.
- R4: A card_rst high interval with no card_clk rising edge is a PROG when card_rst falls. It sets the cell at the current address to 1 and leaves the address unchanged.
- R5: A card_rst high interval with exactly two card_clk rising edges is an ERASE when card_rst falls. It clears all eight cells whose address shares bits [8:3] with the current address, and the address is unchanged. An interval with three or more edges is no command at all.
- R6: Cell a sits in row a/8 at bit position a mod 8. Addresses 192 to 511 read as 0, and PROG or ERASE there changes nothing, raises no busy and leaves reject unchanged.
- R7: With issuer_fuse low, PROG is accepted only for addresses 64 to 111. PROG elsewhere below 192 is refused.
- R8: With issuer_fuse high, PROG and ERASE are accepted for addresses 16 to 191. Cells 0 to 15 can never be written in either configuration.
- R9: With issuer_fuse low, ERASE is accepted only for rows 8 to 12, and only while row r+1 holds at least one set cell. Row 13 and every row outside the counter window refuse ERASE.
- R10: A refused PROG or ERASE leaves every cell unchanged and raises no busy. It sets reject, which stays high until the synchronous reset.
- R11: An accepted PROG or ERASE holds busy high for exactly WR_CYCLES clock cycles. Any command decoded while busy is high is dropped, with no change to address, cells or io_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_rst | input | 1 | Host card reset line |
| card_clk | input | 1 | Host card clock line |
| issuer_fuse | input | 1 | 1 selects the issuer configuration, 0 the user configuration |
| io_out | output | 1 | Registered serial data bit |
| busy | output | 1 | Write timing window active |
| reject | output | 1 | Sticky flag for a refused write |

## Verification
The assertions check the following on every cycle. The circuit identification rows never change. Rows outside the counter window hold still whenever the previous cycle was in user configuration, and the top counter stage never drops to zero in user configuration. The address is frozen while busy is high, the reject flag is sticky, a read beyond the array returns 0, and a write never starts while the timer is running. Other behaviour can only be shown by the bench scenarios: how each rst/clk pattern decodes, the exact length of the busy window, the abacus condition that depends on the contents of the neighbouring stage, and the cell values that result after mixed reads, programs and erases in both configurations.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RESET,
    CMD_READ,
    CMD_PROG,
    CMD_ERASE
  } scm_cmd_e;
endpackage

// File: rtl/scm_cmd_decode.sv
module scm_cmd_decode
  import scm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     card_rst,
  input  logic     card_clk,
  output scm_cmd_e cmd
);
  logic       rst_q, rst_p, ck_q, ck_p;
  logic [1:0] n_edges;
  logic       ck_rise, rl_rise, rl_fall;

  assign ck_rise = ck_q & ~ck_p;
  assign rl_rise = rst_q & ~rst_p;
  assign rl_fall = rst_p & ~rst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q   <= 1'b0;
      rst_p   <= 1'b0;
      ck_q    <= 1'b0;
      ck_p    <= 1'b0;
      n_edges <= 2'd0;
    end else begin
      rst_q <= card_rst;
      rst_p <= rst_q;
      ck_q  <= card_clk;
      ck_p  <= ck_q;
      if (rl_rise)
        n_edges <= 2'd0;
      else if (ck_rise && rst_q && n_edges != 2'd3)
        n_edges <= n_edges + 2'd1;
    end
  end

  always_comb begin
    cmd = CMD_NONE;
    if (rl_fall) begin
      case (n_edges)
        2'd0:    cmd = CMD_PROG;
        2'd1:    cmd = CMD_RESET;
        2'd2:    cmd = CMD_ERASE;
        default: cmd = CMD_NONE;
      endcase
    end else if (ck_rise && !rst_q) begin
      cmd = CMD_READ;
    end
  end

  // R5: an interval with saturated edge count never yields a command
  p_sat_none_r5: assert property (@(posedge clk) disable iff (rst)
    (rl_fall && n_edges == 2'd3) |-> cmd == CMD_NONE);
endmodule

// File: rtl/scm_access.sv
module scm_access
  import scm_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int MEM_BITS = 192,
  parameter int CID_BITS = 16,
  parameter int CTR_BASE = 64,
  parameter int CTR_END  = 112
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              issuer,
  input  logic              next_row_nz,
  input  scm_cmd_e          cmd,
  output logic              in_range,
  output logic              allow
);
  localparam logic [ADDR_W-1:0] L_MEM  = ADDR_W'(MEM_BITS);
  localparam logic [ADDR_W-1:0] L_CID  = ADDR_W'(CID_BITS);
  localparam logic [ADDR_W-1:0] L_CB   = ADDR_W'(CTR_BASE);
  localparam logic [ADDR_W-1:0] L_CE   = ADDR_W'(CTR_END);
  localparam logic [ADDR_W-1:0] L_CTOP = ADDR_W'(CTR_END - 8);

  logic prog_ok, erase_ok;

  always_comb begin
    in_range = addr < L_MEM;
    prog_ok  = issuer ? (addr >= L_CID) : (addr >= L_CB && addr < L_CE);
    erase_ok = issuer ? (addr >= L_CID)
                      : (addr >= L_CB && addr < L_CTOP && next_row_nz);
    allow    = in_range && ((cmd == CMD_PROG && prog_ok) ||
                            (cmd == CMD_ERASE && erase_ok));
  end
endmodule

// File: rtl/scm_write_timer.sv
module scm_write_timer #(
  parameter int WR_CYCLES = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= CW'(WR_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R11: the start request from the top never lands inside a running window
  p_start_idle_r11: assert property (@(posedge clk) disable iff (rst)
    start |-> cnt == '0);
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(WR_CYCLES));
endmodule

// File: rtl/scm_card_ctrl.sv
module scm_card_ctrl
  import scm_pkg::*;
#(
  parameter int              MEM_BITS   = 192,
  parameter int              ADDR_W     = 9,
  parameter int              CID_BITS   = 16,
  parameter int              CTR_BASE   = 64,
  parameter int              CTR_BITS   = 48,
  parameter int              WR_CYCLES  = 12,
  parameter logic [CID_BITS-1:0] CIRCUIT_ID = 16'hA5C3
) (
  input  logic clk,
  input  logic rst,
  input  logic card_rst,
  input  logic card_clk,
  input  logic issuer_fuse,
  output logic io_out,
  output logic busy,
  output logic reject
);
  localparam int ROWS     = MEM_BITS / 8;
  localparam int RIDX_W   = $clog2(ROWS);
  localparam int CTR_END  = CTR_BASE + CTR_BITS;
  localparam int CID_ROWS = CID_BITS / 8;
  localparam int TOP_ROW  = (CTR_END / 8) - 1;
  localparam logic [ADDR_W-1:0] L_MEM = ADDR_W'(MEM_BITS);

  logic [7:0]        mem [ROWS];
  logic [ADDR_W-1:0] addr_q, addr_inc;
  logic [RIDX_W-1:0] cur_row;
  logic [2:0]        cur_bit;
  logic              next_row_nz, rd_bit, in_range, allow, start;
  scm_cmd_e          cmd;

  function automatic logic [7:0] init_row(int r);
    logic [7:0] v;
    v = '0;
    for (int b = 0; b < 8; b++)
      if (r * 8 + b < CID_BITS) v[b] = CIRCUIT_ID[r * 8 + b];
    return v;
  endfunction

  scm_cmd_decode u_dec (
    .clk(clk), .rst(rst), .card_rst(card_rst), .card_clk(card_clk), .cmd(cmd)
  );

  scm_access #(
    .ADDR_W(ADDR_W), .MEM_BITS(MEM_BITS), .CID_BITS(CID_BITS),
    .CTR_BASE(CTR_BASE), .CTR_END(CTR_END)
  ) u_acc (
    .addr(addr_q), .issuer(issuer_fuse), .next_row_nz(next_row_nz),
    .cmd(cmd), .in_range(in_range), .allow(allow)
  );

  scm_write_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .busy(busy)
  );

  assign addr_inc = addr_q + 1'b1;
  assign cur_row  = RIDX_W'(addr_q >> 3);
  assign cur_bit  = addr_q[2:0];
  assign start    = !busy && allow;

  always_comb begin
    next_row_nz = 1'b0;
    if (in_range && cur_row < RIDX_W'(ROWS - 1))
      next_row_nz = |mem[cur_row + RIDX_W'(1)];
    rd_bit = 1'b0;
    if (addr_inc < L_MEM)
      rd_bit = mem[RIDX_W'(addr_inc >> 3)][addr_inc[2:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      io_out <= 1'b0;
      reject <= 1'b0;
      for (int r = 0; r < ROWS; r++) mem[r] <= init_row(r);
    end else if (!busy) begin
      case (cmd)
        CMD_RESET: begin
          addr_q <= '0;
          io_out <= mem[0][0];
        end
        CMD_READ: begin
          addr_q <= addr_inc;
          io_out <= rd_bit;
        end
        CMD_PROG, CMD_ERASE: begin
          if (in_range) begin
            if (!allow)                reject             <= 1'b1;
            else if (cmd == CMD_PROG)  mem[cur_row][cur_bit] <= 1'b1;
            else                       mem[cur_row]       <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  // R11: address frozen while the write window is open
  p_busy_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(addr_q));
  // R10: reject is sticky
  p_reject_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    reject |=> reject);
  // R6: reads beyond the array return zero
  p_oor_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd == CMD_READ && addr_inc >= L_MEM) |=> !io_out);
  // R6: no write window for out-of-range addresses
  p_oor_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
    !in_range |-> !start);
  // R9: the top counter stage never empties in user configuration
  p_top_stage_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(issuer_fuse) && $past(|mem[TOP_ROW])) |-> (|mem[TOP_ROW]));

  for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
    if (r < CID_ROWS) begin : g_cid
      // R8: circuit identification rows are read-only
      p_cid_ro_r8: assert property (@(posedge clk) disable iff (rst)
        $stable(mem[r]));
    end else if (r * 8 < CTR_BASE || r * 8 >= CTR_END) begin : g_lock
      // R7: rows outside the counter window locked in user configuration
      p_user_lock_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(issuer_fuse) |-> $stable(mem[r]));
    end
  end
endmodule

// File: tb/scm_card_ctrl_bench.sv
module scm_card_ctrl_bench;
  localparam int WR = 12;
  localparam logic [15:0] CID = 16'hA5C3;

  logic clk = 1'b0, rst = 1'b1, card_rst = 1'b0, card_clk = 1'b0, issuer_fuse = 1'b0;
  logic io_out, busy, reject;
  int checks = 0, errors = 0;
  bit m [192];
  int m_addr = 0;
  bit m_rej = 1'b0;

  always #4 clk = ~clk;

  scm_card_ctrl #(.WR_CYCLES(WR), .CIRCUIT_ID(CID)) u_scm_card_ctrl (
    .clk(clk), .rst(rst), .card_rst(card_rst), .card_clk(card_clk),
    .issuer_fuse(issuer_fuse), .io_out(io_out), .busy(busy), .reject(reject)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(bit r, bit c);
    card_rst = r; card_clk = c; step(4);
  endtask

  function automatic bit bit_at(int a);
    return (a < 192) ? m[a] : 1'b0;
  endfunction

  function automatic bit row_nz(int r);
    bit v = 0;
    for (int b = 0; b < 8; b++) v |= m[r * 8 + b];
    return v;
  endfunction

  function automatic bit prog_ok(int a);
    if (issuer_fuse) return a >= 16 && a < 192;
    return a >= 64 && a < 112;
  endfunction

  function automatic bit erase_ok(int a);
    int r = a / 8;
    if (issuer_fuse) return a >= 16 && a < 192;
    return r >= 8 && r <= 12 && row_nz(r + 1);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 192; i++) m[i] = (i < 16) ? CID[i] : 1'b0;
    m_addr = 0; m_rej = 0;
  endtask

  task automatic c_read(string req);
    pins(0, 1); pins(0, 0);
    m_addr = (m_addr + 1) % 512;
    check(req, io_out, bit_at(m_addr));
  endtask

  task automatic c_reset();
    pins(1, 0); pins(1, 1); pins(1, 0); pins(0, 0);
    m_addr = 0;
    check("R3 reset data", io_out, m[0]);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 200) begin step(1); t++; end
    check("R11 busy ends", busy, 0);
  endtask

  // edges: 0 = PROG, 2 = ERASE, 3 = no command
  task automatic c_write(int edges, bit do_wait);
    bit ok;
    pins(1, 0);
    for (int k = 0; k < edges; k++) begin pins(1, 1); pins(1, 0); end
    pins(0, 0);
    if (edges == 3) begin
      check("R5 three edges no busy", busy, 0);
      return;
    end
    ok = (edges == 0) ? prog_ok(m_addr) : erase_ok(m_addr);
    if (m_addr >= 192) begin
      check("R6 oor no busy", busy, 0);
    end else if (ok) begin
      if (edges == 0) m[m_addr] = 1'b1;
      else for (int b = 0; b < 8; b++) m[(m_addr / 8) * 8 + b] = 1'b0;
      check("R11 busy after accept", busy, 1);
    end else begin
      m_rej = 1'b1;
      check("R10 refused no busy", busy, 0);
    end
    check("R10 reject flag", reject, m_rej);
    if (do_wait) wait_idle();
  endtask

  task automatic goto_addr(int a);
    c_reset();
    for (int i = 0; i < a; i++) c_read("R2 walk");
  endtask

  task automatic sweep(string req);
    c_reset();
    for (int i = 0; i < 200; i++) c_read(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    model_reset();
    step(4); rst = 1'b0; step(2);
    // R1 reset state
    check("R1 io_out", io_out, 0);
    check("R1 busy", busy, 0);
    check("R1 reject", reject, 0);
    sweep("R1 initial contents");

    // R7 user program window
    goto_addr(64);  c_write(0, 1);
    c_read("R4 address kept after prog");
    goto_addr(20);  c_write(0, 1);   // refused: R7, R10
    goto_addr(112); c_write(0, 1);   // refused at window end: R7
    // R6 out of range
    goto_addr(195); c_write(0, 1); c_write(2, 1);
    c_read("R6 read beyond array");
    // R5 three edges: no command, address unchanged
    goto_addr(64); c_write(3, 1); c_read("R5 address kept");
    // R9 abacus
    goto_addr(66); c_write(0, 1);
    c_write(2, 1);                   // row 9 empty: refused (R9)
    goto_addr(73); c_write(0, 1);
    goto_addr(65); c_write(2, 1);    // row 9 nonzero: accepted (R9)
    goto_addr(105); c_write(0, 1); c_write(2, 1); // top stage refused (R9)
    goto_addr(24); c_write(2, 1);    // outside window refused (R9)
    // R8 issuer configuration
    issuer_fuse = 1'b1;
    goto_addr(20);  c_write(0, 1);
    goto_addr(150); c_write(0, 1);
    goto_addr(5);   c_write(0, 1);   // circuit id refused
    goto_addr(105); c_write(2, 1);   // top stage erasable for issuer
    goto_addr(21);  c_write(2, 1);
    issuer_fuse = 1'b0;
    sweep("R8 contents after writes");

    // R11 busy length and dropped commands
    goto_addr(67);
    pins(1, 0); card_rst = 1'b0;
    m[67] = 1'b1;
    cnt = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (busy) cnt++; end
    check("R11 busy length", cnt, WR);
    goto_addr(68);
    pins(1, 0); pins(0, 0); m[68] = 1'b1;
    pins(0, 1); pins(0, 0);           // read dropped while busy
    wait_idle();
    c_read("R11 read during busy dropped");
    sweep("R11 contents");

    // constrained random phase with fresh state
    rst = 1'b1; step(3); rst = 1'b0; step(2); model_reset();
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 100;
      if ($urandom % 20 == 0) issuer_fuse = ~issuer_fuse;
      if (r < 8)       c_reset();
      else if (r < 70) c_read("R2 random read");
      else if (r < 86) c_write(0, 1);
      else if (r < 97) c_write(2, 1);
      else             c_write(3, 1);
    end
    issuer_fuse = 1'b0;
    sweep("R10 final contents");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule